// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Serial Loader

This block is the digital side of a four-channel, 8-bit converter. A host shifts an 11-bit word in over a two-wire serial link made of a clock and a data line. A load strobe then moves the captured word into the input latch of the channel it addresses. Each channel has a second, output latch behind the input latch. The output latch holds the 8-bit code and the range bit that drive the analog converter.

An update control sets how the output latches follow the input latches. While the control is low, a load goes straight through to the addressed channel's output. While the control is high, loads only fill the input latches. A later falling edge of the control then copies all four input latches to the outputs in the same cycle, so the channels change together.

The three serial-side inputs and the data line are sampled in the system clock domain, and their edges are found there. The serial clock must run at least four times slower than the system clock. Reset is asynchronous and active low, and it is released in step with the system clock.

Top module: `quad_serial_loader`

## Requirements
- R1: A data bit is sampled on each falling edge of the serial clock. The word is sent most significant bit first. Word bits 10:9 are the channel address (0 is channel A, 1 is B, 2 is C, 3 is D), bit 8 is the range bit, and bits 7:0 are the code.
- R2: Only the last 11 bits shifted in before a load strobe falling edge are used. Any bits sent before those have no effect.
- R3: While the update control is low, a load strobe falling edge writes the addressed channel's input latch and output latch together. The other channels' outputs keep their values.
- R4: While the update control is high, a load strobe falling edge writes only the addressed channel's input latch. No output changes.
- R5: A falling edge of the update control copies all four input latches into their output latches in the same cycle.
- R6: The range bit is stored in the same latches as the code and moves with it. A range output of 1 selects 2x gain and 0 selects 1x gain.
- R7: Reset clears every code output to 0 and every range output to 0 (1x).
- R8: If a load falling edge and an update-control falling edge are detected in the same system cycle, the new word is written to the input latch first, and the transfer to the outputs then carries it.
- R9: Rising edges of the load strobe and of the update control change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data |
| load_n_i | input | 1 | Load strobe, acts on its falling edge |
| upd_i | input | 1 | Update control: low for pass-through, high to hold, falling edge to transfer |
| codes_o | output | 32 | Output codes; channel k is in bits 8k+7:8k |
| gain2x_o | output | 4 | Range bits, one per channel; 1 selects 2x |

## Verification
The bench sends every 8-bit code, cycling through the channels and both range values, in pass-through mode. A design that sliced the word wrongly or routed a code to the wrong channel fails on these codes. Hold mode is tested with loads to every channel, checking after each load that no output moved. It is followed by a single transfer, which a design that copied only one channel, or let a load leak through, gets wrong.

Other runs cover:
- words preceded by junk bits, which a frame counter that did not drop the early bits would corrupt;
- a load and a transfer that arrive in the same cycle, where a design that transferred the old input latch would show the stale code;
- rising edges of both controls;
- a reset in the middle of a run.

// File: rtl/qsl_pkg.sv
package qsl_pkg;
  localparam int QSL_NUM_CH = 4;
  localparam int QSL_CODE_W = 8;
  localparam int QSL_SYNC_STAGES = 2;

  function automatic int qsl_frame_w(input int num_ch, input int code_w);
    return $clog2(num_ch) + 1 + code_w;
  endfunction
endpackage

// File: rtl/qsl_edge_det.sv
module qsl_edge_det #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    prev_d = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
      prev_q <= prev_d;
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;

  // A falling edge needs a high sample before it, so no bit falls twice in a row (R1)
  assert_single_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_o) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/qsl_shift.sv
module qsl_shift #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] frame_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign frame_o = sr_q;

  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(bit_i)));
endmodule

// File: rtl/qsl_chan.sv
module qsl_chan #(
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          hold,
  input  logic          xfer,
  input  logic [WW-1:0] word_i,
  output logic [WW-1:0] out_o
);
  logic [WW-1:0] in_q, in_d, out_q, out_d;

  always_comb begin
    in_d  = in_q;
    out_d = out_q;
    if (wr_en) in_d = word_i;
    if (xfer)                out_d = in_d;
    else if (wr_en && !hold) out_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold) |=> (out_q == in_q));
  assert_hold_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold) |=> $stable(out_q));
  assert_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (out_q == in_q));
  assert_load_then_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && xfer) |=> (out_q == $past(word_i)));
endmodule

// File: rtl/quad_serial_loader.sv
module quad_serial_loader
  import qsl_pkg::*;
#(
  parameter int NUM_CH = QSL_NUM_CH,
  parameter int CODE_W = QSL_CODE_W,
  parameter int SYNC_STAGES = QSL_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk_i,
  input  logic                     ser_dat_i,
  input  logic                     load_n_i,
  input  logic                     upd_i,
  output logic [NUM_CH*CODE_W-1:0] codes_o,
  output logic [NUM_CH-1:0]        gain2x_o
);
  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int FRAME_W = qsl_frame_w(NUM_CH, CODE_W);
  localparam int WORD_W  = CODE_W + 1;
  localparam int IDX_SCLK = 0, IDX_SDAT = 1, IDX_LOAD = 2, IDX_UPD = 3;

  logic [1:0] rst_sync_q, rst_sync_d;
  logic       rst_core_n;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end
  assign rst_core_n = rst_sync_q[1];

  logic [3:0] raw, lvl, fall;
  assign raw = {upd_i, load_n_i, ser_dat_i, ser_clk_i};

  qsl_edge_det #(.W(4), .STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_core_n), .async_i(raw), .level_o(lvl), .fall_o(fall)
  );

  logic [FRAME_W-1:0] frame;
  qsl_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .shift_en(fall[IDX_SCLK]),
    .bit_i(lvl[IDX_SDAT]), .frame_o(frame)
  );

  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word;
  assign addr = frame[FRAME_W-1 -: ADDR_W];
  assign word = frame[WORD_W-1:0];

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [WORD_W-1:0] ch_out;
      logic              ch_sel;
      assign ch_sel = fall[IDX_LOAD] && (addr == ADDR_W'(k));
      qsl_chan #(.WW(WORD_W)) u_chan (
        .clk(clk), .rst_n(rst_core_n), .wr_en(ch_sel), .hold(lvl[IDX_UPD]),
        .xfer(fall[IDX_UPD]), .word_i(word), .out_o(ch_out)
      );
      assign codes_o[k*CODE_W +: CODE_W] = ch_out[CODE_W-1:0];
      assign gain2x_o[k] = ch_out[CODE_W];
    end
  endgenerate
endmodule

// File: tb/sim_quad_serial_loader.sv
module sim_quad_serial_loader;
  localparam int CLK_P = 10;
  localparam int HALF_SCLK = 4;

  logic clk = 0, rst_n = 0, sclk = 0, sdat = 0, load_n = 1, upd = 0;
  logic [31:0] codes;
  logic [3:0]  gains;
  logic [8:0]  in_m [4];
  logic [8:0]  out_m [4];
  logic [10:0] cur_frame;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  quad_serial_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .load_n_i(load_n), .upd_i(upd), .codes_o(codes), .gain2x_o(gains)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      logic [8:0] act;
      act = {gains[k], codes[k*8 +: 8]};
      n_chk++;
      if (act !== out_m[k]) begin
        n_bad++;
        $display("FAIL %s ch%0d actual=%h expected=%h", req, k, act, out_m[k]);
      end
    end
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_clk(2);
      sclk = 1;
      wait_clk(HALF_SCLK);
      sclk = 0;
      wait_clk(HALF_SCLK);
    end
  endtask

  task automatic send_frame(input logic [1:0] ch, input logic g, input logic [7:0] c);
    cur_frame = {ch, g, c};
    send_bits({5'b0, cur_frame}, 11);
  endtask

  task automatic pulse_load();
    load_n = 0;
    in_m[cur_frame[10:9]] = cur_frame[8:0];
    if (!upd) out_m[cur_frame[10:9]] = cur_frame[8:0];
    wait_clk(6);
    load_n = 1;
    wait_clk(8);
  endtask

  task automatic set_upd(input logic v);
    if (upd && !v) for (int k = 0; k < 4; k++) out_m[k] = in_m[k];
    upd = v;
    wait_clk(8);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin in_m[k] = '0; out_m[k] = '0; end
    wait_clk(3);
    check_all("R7 reset");
    rst_n = 1;
    wait_clk(6);
    check_all("R7 after release");

    // R1 R3 R6: every code, rotating channel and range, pass-through
    for (int c = 0; c < 256; c++) begin
      send_frame(2'(c), c[0] ^ c[4], 8'(c));
      pulse_load();
      check_all("R3/R6 pass-through sweep");
    end
    check_all("R1 sweep end");

    // R2: junk bits before the real word
    cur_frame = {2'd2, 1'b1, 8'hA5};
    send_bits({5'b10111, cur_frame}, 16);
    pulse_load();
    check_all("R2 leading junk");

    // R4: hold mode, load each channel, no output moves
    set_upd(1);
    check_all("R9 upd rise");
    for (int k = 0; k < 4; k++) begin
      send_frame(2'(k), k[0], 8'(8'h3C + 17 * k));
      pulse_load();
      check_all("R4 hold no output change");
    end
    // R5: transfer all at once
    set_upd(0);
    check_all("R5 transfer all");

    // R8: simultaneous load and update falls
    set_upd(1);
    send_frame(2'd1, 1'b0, 8'h77);
    in_m[1] = cur_frame[8:0];
    for (int k = 0; k < 4; k++) out_m[k] = in_m[k];
    load_n = 0;
    upd = 0;
    wait_clk(8);
    check_all("R8 same-cycle load and transfer");
    load_n = 1;
    wait_clk(8);
    check_all("R9 load rise");

    // R7: reset mid-run
    rst_n = 0;
    for (int k = 0; k < 4; k++) begin in_m[k] = '0; out_m[k] = '0; end
    wait_clk(2);
    check_all("R7 mid-run reset");
    rst_n = 1;
    wait_clk(6);
    set_upd(1);
    set_upd(0);
    check_all("R7 input latches cleared");
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule